// File: doc/BRIEF.md
# SPI Flash User-Mode Transfer Engine

This block is the software-driven half of a serial flash controller. It has a 32-bit register bus with word offsets. Through that bus software sets the number of bits to shift, the SCLK half-period, whether MISO is captured, and whether chip select stays low once the transfer is over. Software also fills a 64-byte data buffer. Writing the start bit in the command register launches one transfer.

During a transfer the engine walks the buffer bit by bit. It drives each bit on MOSI in SPI mode 0, starting with byte 0 and sending each byte MSB first. When capture is on, the MISO bit sampled at each rising SCLK edge replaces the bit just sent, so after a full-duplex transfer the buffer holds the reply. When the transfer ends, the engine raises a sticky done flag that software polls. A soft-reset bit aborts a transfer at any point. A mode bit must select master operation, and the bit that enables the memory-mapped read path must be cleared, before a start is accepted.

The sequencer has five states:
- IDLE: waiting for a start.
- LEAD: chip select is low and SCLK is still low.
- HIGH: SCLK is high.
- LOW: SCLK is low between bits.
- TAIL: the final half-period after the last falling edge.

It has these transitions:
- launch: IDLE to LEAD.
- first-rise: LEAD to HIGH.
- fall: HIGH to LOW.
- rise: LOW to HIGH.
- last-fall: HIGH to TAIL.
- finish: TAIL to IDLE.
- abort: any state to IDLE, on soft reset.

Every timed state lasts (half + 1) clock cycles.

Top module: `sfc_user_engine`

## Requirements
- R1: After reset the register values are as follows.
  - Control (0x08) reads 0x00020000, so the memory-mapped path is enabled.
  - Clock (0x18) reads 0x00000001.
  - Command, user, user-1, user-4 and slave read 0.
  - Every buffer word reads 0.
  - cs_n is 1 and SCLK is 0.
- R2: The buffer is 16 words at 0x40..0x7C. Byte b lives in word b/4, bits 8*(b%4)+7 .. 8*(b%4). A written word reads back unchanged.
- R3: A transfer starts when software writes 1 to command bit 18 while all of these hold: the engine is idle, control bit 17 is 0 and slave bit 30 is 0. Command bit 18 reads 1 while a transfer is busy.
- R4: User-1 bits 25:17 hold (bits − 1). A transfer makes exactly that many rising SCLK edges. Buffer bit k is byte k/8, bit 7 − k%8, and bits leave in increasing k.
- R5: The transfer follows SPI mode 0 with these timing rules.
  - SCLK idles low.
  - MOSI changes only on falling edges.
  - MISO is sampled at each rising edge.
  - cs_n falls one half-period before the first rising edge.
  - Each half-period lasts (clock bits 5:0 + 1) clock cycles.
- R6: With user bit 0 set, each sampled MISO bit overwrites buffer bit k. With it clear, the buffer is left unchanged.
- R7: Slave bit 4 (done) becomes 1 when a transfer finishes. Writing 0 to it clears it, and writing 1 leaves it unchanged.
- R8: When user-4 bit 30 is 1, cs_n stays low after the transfer ends. When it is 0, cs_n rises one half-period after the last falling edge.
- R9: A start written while a transfer is busy is ignored, and the running transfer completes with its original bit count.
- R10: A start is ignored while control bit 17 is 1 or slave bit 30 is 1. In that case no SCLK edge occurs and cs_n stays high.
- R11: Writing 1 to slave bit 31 has these effects.
  - Any transfer is aborted.
  - The engine returns to idle.
  - cs_n is released and SCLK is driven low.
  - Done is cleared.
  - Bit 31 itself reads 0.
- R12: While a transfer is busy, bus writes to the buffer and to the configuration registers (control, clock, user, user-1, user-4) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions check several rules on every cycle:
- SCLK is never high while chip select is released.
- SCLK moves only when a phase expires or on abort.
- The bit index stays within the programmed count.
- LEAD is entered only from IDLE.
- Chip select rises only at finish without hold, or on abort.
- Done follows every completed transfer.
- A blocked start leaves the engine idle.
- Bus writes never collide with capture writes.

Some behaviour only the directed scenarios can show:
- The bit order on MOSI and the in-place replacement of the buffer by MISO data.
- The exact half-period timings.
- That a second start, writes issued mid-transfer, and the write-1-to-done case leave no trace on the buffer, the registers or the SCLK count.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;
    localparam int SFC_BUF_BYTES = 64;
    localparam int SFC_ADDR_W    = 7;
    localparam int SFC_DIV_W     = 6;
    localparam int SFC_IDX_W     = $clog2(SFC_BUF_BYTES * 8);

    // word indices of the control registers (byte offset / 4)
    localparam logic [4:0] WIX_CMD   = 5'h00;
    localparam logic [4:0] WIX_CTRL  = 5'h02;
    localparam logic [4:0] WIX_CLOCK = 5'h06;
    localparam logic [4:0] WIX_USER  = 5'h07;
    localparam logic [4:0] WIX_USER1 = 5'h08;
    localparam logic [4:0] WIX_USER4 = 5'h0B;
    localparam logic [4:0] WIX_SLAVE = 5'h0C;

    localparam int B_GO      = 18;
    localparam int B_MAPEN   = 17;
    localparam int B_CAPTURE = 0;
    localparam int B_CNT_LSB = 17;
    localparam int B_HOLD    = 30;
    localparam int B_DONE    = 4;
    localparam int B_MODE    = 30;
    localparam int B_SWRST   = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } sfc_state_e;
endpackage

// File: rtl/sfc_phase_timer.sv
`timescale 1ns/1ps
module sfc_phase_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] reload_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= reload_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sfc_data_buffer.sv
`timescale 1ns/1ps
module sfc_data_buffer #(
    parameter int BYTES = 64,
    localparam int WORDS  = BYTES / 4,
    localparam int WSEL_W = $clog2(WORDS),
    localparam int BSEL_W = $clog2(BYTES),
    localparam int IDX_W  = $clog2(BYTES * 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we_i,
    input  logic [WSEL_W-1:0] bus_word_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              rd_bit_o,
    input  logic              cap_we_i,
    input  logic [IDX_W-1:0]  cap_idx_i,
    input  logic              cap_bit_i
);
    logic [7:0] mem_q [BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < BYTES; b++) begin
                mem_q[b] <= '0;
            end
        end else begin
            if (bus_we_i) begin
                for (int lane = 0; lane < 4; lane++) begin
                    mem_q[{bus_word_i, 2'(lane)}] <= bus_wdata_i[8*lane +: 8];
                end
            end
            if (cap_we_i) begin
                mem_q[cap_idx_i[IDX_W-1:3]][~cap_idx_i[2:0]] <= cap_bit_i;
            end
        end
    end

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign bus_rdata_o[8*g +: 8] = mem_q[{bus_word_i, 2'(g)}];
    end

    logic [BSEL_W-1:0] rd_byte;
    assign rd_byte  = rd_idx_i[IDX_W-1:3];
    assign rd_bit_o = mem_q[rd_byte][~rd_idx_i[2:0]];

    // R12
    lane_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we_i && cap_we_i));
endmodule

// File: rtl/sfc_shift_seq.sv
`timescale 1ns/1ps
module sfc_shift_seq
    import sfc_pkg::*;
#(
    parameter int IDX_W = SFC_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic             expired_i,
    input  logic [IDX_W-1:0] last_i,
    input  logic             hold_i,
    input  logic             capture_i,
    input  logic             tx_bit_i,
    input  logic             miso_i,
    output logic             load_o,
    output logic             busy_o,
    output logic             fin_o,
    output logic             sclk_o,
    output logic             cs_n_o,
    output logic             mosi_o,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic             cap_we_o,
    output logic [IDX_W-1:0] cap_idx_o,
    output logic             cap_bit_o
);
    sfc_state_e       state_q, state_d;
    logic [IDX_W-1:0] bit_idx_q, last_q;
    logic             sclk_q, cs_n_q, mosi_q;
    logic             is_last, ev_launch, ev_rise, ev_fall, ev_finish;

    assign is_last = (bit_idx_q == last_q);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)   state_d = ST_LEAD;
            ST_LEAD: if (expired_i) state_d = ST_HIGH;
            ST_HIGH: if (expired_i) state_d = is_last ? ST_TAIL : ST_LOW;
            ST_LOW:  if (expired_i) state_d = ST_HIGH;
            ST_TAIL: if (expired_i) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
        if (abort_i) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign ev_launch = (state_q == ST_IDLE) && start_i && !abort_i;
    assign ev_rise   = ((state_q == ST_LEAD) || (state_q == ST_LOW)) && expired_i && !abort_i;
    assign ev_fall   = (state_q == ST_HIGH) && expired_i && !abort_i;
    assign ev_finish = (state_q == ST_TAIL) && expired_i && !abort_i;

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q    <= 1'b0;
            cs_n_q    <= 1'b1;
            mosi_q    <= 1'b0;
            bit_idx_q <= '0;
            last_q    <= '0;
        end else if (abort_i) begin
            sclk_q    <= 1'b0;
            cs_n_q    <= 1'b1;
            bit_idx_q <= '0;
        end else begin
            if (ev_launch) begin
                cs_n_q    <= 1'b0;
                mosi_q    <= tx_bit_i;
                bit_idx_q <= '0;
                last_q    <= last_i;
            end
            if (ev_rise) sclk_q <= 1'b1;
            if (ev_fall) begin
                sclk_q <= 1'b0;
                if (!is_last) begin
                    bit_idx_q <= bit_idx_q + 1'b1;
                    mosi_q    <= tx_bit_i;
                end
            end
            if (ev_finish && !hold_i) cs_n_q <= 1'b1;
        end
    end

    assign load_o    = ev_launch || ev_rise || ev_fall;
    assign busy_o    = (state_q != ST_IDLE);
    assign fin_o     = ev_finish;
    assign sclk_o    = sclk_q;
    assign cs_n_o    = cs_n_q;
    assign mosi_o    = mosi_q;
    assign rd_idx_o  = (state_q == ST_IDLE) ? '0 : bit_idx_q + 1'b1;
    assign cap_we_o  = ev_rise && capture_i;
    assign cap_idx_o = bit_idx_q;
    assign cap_bit_o = miso_i;

    // R5
    sclk_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_q |-> !cs_n_q);
    // R5
    sclk_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk_q) |-> ($past(expired_i) || $past(abort_i)));
    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (bit_idx_q <= last_q));
    // R9
    lead_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_LEAD) |-> ($past(state_q) == ST_IDLE));
    // R8
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_q) |-> ($past(abort_i) || (($past(state_q) == ST_TAIL) && !$past(hold_i))));
    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> ((state_q == ST_IDLE) && cs_n_q && !sclk_q));
endmodule

// File: rtl/sfc_user_engine.sv
`timescale 1ns/1ps
module sfc_user_engine
    import sfc_pkg::*;
#(
    parameter int BUF_BYTES = SFC_BUF_BYTES,
    localparam int IDX_W  = $clog2(BUF_BYTES * 8),
    localparam int WSEL_W = $clog2(BUF_BYTES / 4)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [SFC_ADDR_W-1:0] bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  spi_sclk,
    output logic                  spi_cs_n,
    output logic                  spi_mosi,
    input  logic                  spi_miso
);
    logic                 map_en_q, cap_en_q, hold_q, mode_q, done_q;
    logic [SFC_DIV_W-1:0] half_q;
    logic [IDX_W-1:0]     cnt_m1_q;

    logic [4:0]        word;
    logic              in_buf, wr, cfg_we, slv_we, buf_we, sw_rst, start_req, start_ok;
    logic              busy, seq_fin, load, expired, tx_bit, cap_we, cap_bit;
    logic [IDX_W-1:0]  rd_idx, cap_idx;
    logic [31:0]       buf_rdata;
    logic [WSEL_W-1:0] buf_word;

    assign word      = bus_addr[SFC_ADDR_W-1:2];
    assign in_buf    = bus_addr[SFC_ADDR_W-1];
    assign buf_word  = bus_addr[WSEL_W+1:2];
    assign wr        = bus_sel && bus_we;
    assign cfg_we    = wr && !in_buf && !busy;
    assign slv_we    = wr && !in_buf && (word == WIX_SLAVE);
    assign buf_we    = wr && in_buf && !busy;
    assign sw_rst    = slv_we && bus_wdata[B_SWRST];
    assign start_req = wr && !in_buf && (word == WIX_CMD) && bus_wdata[B_GO];
    assign start_ok  = start_req && !busy && !map_en_q && !mode_q && !sw_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_en_q <= 1'b1;
            half_q   <= SFC_DIV_W'(1);
            cap_en_q <= 1'b0;
            cnt_m1_q <= '0;
            hold_q   <= 1'b0;
            mode_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            if (cfg_we && (word == WIX_CTRL))  map_en_q <= bus_wdata[B_MAPEN];
            if (cfg_we && (word == WIX_CLOCK)) half_q   <= bus_wdata[SFC_DIV_W-1:0];
            if (cfg_we && (word == WIX_USER))  cap_en_q <= bus_wdata[B_CAPTURE];
            if (cfg_we && (word == WIX_USER1)) cnt_m1_q <= bus_wdata[B_CNT_LSB +: IDX_W];
            if (cfg_we && (word == WIX_USER4)) hold_q   <= bus_wdata[B_HOLD];
            if (slv_we)                        mode_q   <= bus_wdata[B_MODE];
            if (sw_rst)       done_q <= 1'b0;
            else if (seq_fin) done_q <= 1'b1;
            else if (slv_we)  done_q <= done_q && bus_wdata[B_DONE];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (in_buf) begin
            bus_rdata = buf_rdata;
        end else begin
            case (word)
                WIX_CMD:   bus_rdata[B_GO]                 = busy;
                WIX_CTRL:  bus_rdata[B_MAPEN]              = map_en_q;
                WIX_CLOCK: bus_rdata[SFC_DIV_W-1:0]        = half_q;
                WIX_USER:  bus_rdata[B_CAPTURE]            = cap_en_q;
                WIX_USER1: bus_rdata[B_CNT_LSB +: IDX_W]   = cnt_m1_q;
                WIX_USER4: bus_rdata[B_HOLD]               = hold_q;
                WIX_SLAVE: begin
                    bus_rdata[B_MODE] = mode_q;
                    bus_rdata[B_DONE] = done_q;
                end
                default:   bus_rdata = '0;
            endcase
        end
    end

    sfc_phase_timer #(.W(SFC_DIV_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .reload_i  (half_q),
        .expired_o (expired)
    );

    sfc_data_buffer #(.BYTES(BUF_BYTES)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we_i    (buf_we),
        .bus_word_i  (buf_word),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (buf_rdata),
        .rd_idx_i    (rd_idx),
        .rd_bit_o    (tx_bit),
        .cap_we_i    (cap_we),
        .cap_idx_i   (cap_idx),
        .cap_bit_i   (cap_bit)
    );

    sfc_shift_seq #(.IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_ok),
        .abort_i   (sw_rst),
        .expired_i (expired),
        .last_i    (cnt_m1_q),
        .hold_i    (hold_q),
        .capture_i (cap_en_q),
        .tx_bit_i  (tx_bit),
        .miso_i    (spi_miso),
        .load_o    (load),
        .busy_o    (busy),
        .fin_o     (seq_fin),
        .sclk_o    (spi_sclk),
        .cs_n_o    (spi_cs_n),
        .mosi_o    (spi_mosi),
        .rd_idx_o  (rd_idx),
        .cap_we_o  (cap_we),
        .cap_idx_o (cap_idx),
        .cap_bit_o (cap_bit)
    );

    // R7
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_fin && !sw_rst) |=> done_q);
    // R10
    blocked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !busy && (map_en_q || mode_q)) |=> !busy);
endmodule

// File: tb/test_sfc_user_engine.sv
`timescale 1ns/1ps
module test_sfc_user_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    always #10 clk = ~clk;

    sfc_user_engine i_sfc_user_engine (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0;
    int fails  = 0;

    logic [7:0] tx_b  [64];
    logic [7:0] rsp_b [64];
    logic       mon_bits [512];
    int  rise_cnt = 0, fall_cnt = 0, rise_base = 0, fall_base = 0;
    int  cs_rise_cnt = 0, cs_viol = 0;
    time t_rise = 0, t_fall = 0, t_first = 0, t_csf = 0, t_csr = 0;
    logic [31:0] miso_k;

    // slave model: next reply bit after every falling SCLK edge
    assign miso_k   = 32'(fall_cnt - fall_base);
    assign spi_miso = (miso_k < 32'd512) ? rsp_b[miso_k[8:3]][3'd7 - miso_k[2:0]] : 1'b0;

    always @(posedge spi_sclk) begin
        if (rise_cnt == rise_base) t_first = $time;
        if (spi_cs_n) cs_viol++;
        mon_bits[(rise_cnt - rise_base) & 511] = spi_mosi;
        rise_cnt++;
        t_rise = $time;
    end
    always @(negedge spi_sclk) begin
        fall_cnt++;
        t_fall = $time;
    end
    always @(negedge spi_cs_n) t_csf = $time;
    always @(posedge spi_cs_n) begin
        cs_rise_cnt++;
        t_csr = $time;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] pack(input logic [7:0] b [64], input int w);
        return {b[4*w+3], b[4*w+2], b[4*w+1], b[4*w]};
    endfunction

    task automatic load_buf();
        for (int w = 0; w < 16; w++) bus_wr(7'(32'h40 + 4*w), pack(tx_b, w));
    endtask

    task automatic arm();
        rise_base = rise_cnt;
        fall_base = fall_cnt;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] d;
        d = '0;
        for (int i = 0; i < 20000; i++) begin
            bus_rd(7'h30, d);
            if (d[4]) break;
        end
        chk(req, {31'b0, d[4]}, 32'd1);
    endtask

    task automatic setup(input int nbits, input bit cap, input bit hold, input int half);
        bus_wr(7'h08, 32'h0);
        bus_wr(7'h18, 32'(half));
        bus_wr(7'h1C, {31'b0, cap});
        bus_wr(7'h20, 32'(nbits - 1) << 17);
        bus_wr(7'h2C, {1'b0, hold, 30'b0});
        bus_wr(7'h30, 32'h0);
        load_buf();
        arm();
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 64; i++) begin
            tx_b[i]  = 8'((i * 37 + seed) ^ 8'h5A);
            rsp_b[i] = 8'((i * 91 + seed * 3) ^ 8'hC3);
        end
    endtask

    // compare MOSI stream against tx bits, and buffer against expected contents
    task automatic chk_mosi(input string req, input int nbits);
        int bad;
        bad = 0;
        for (int k = 0; k < nbits; k++)
            if (mon_bits[k] !== tx_b[k/8][7 - (k%8)]) bad++;
        chk(req, 32'(bad), 32'd0);
    endtask

    task automatic chk_buf(input string req, input int nbits, input bit cap);
        logic [7:0]  e [64];
        logic [31:0] d;
        for (int i = 0; i < 64; i++) e[i] = tx_b[i];
        if (cap)
            for (int k = 0; k < nbits; k++) e[k/8][7 - (k%8)] = rsp_b[k/8][7 - (k%8)];
        for (int w = 0; w < 16; w++) begin
            bus_rd(7'(32'h40 + 4*w), d);
            chk(req, d, pack(e, w));
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 cs_n", {31'b0, spi_cs_n}, 32'd1);
        chk("R1 sclk", {31'b0, spi_sclk}, 32'd0);
        bus_rd(7'h00, d); chk("R1 cmd", d, 32'h0);
        bus_rd(7'h08, d); chk("R1 ctrl", d, 32'h0002_0000);
        bus_rd(7'h18, d); chk("R1 clock", d, 32'h1);
        bus_rd(7'h1C, d); chk("R1 user", d, 32'h0);
        bus_rd(7'h20, d); chk("R1 user1", d, 32'h0);
        bus_rd(7'h2C, d); chk("R1 user4", d, 32'h0);
        bus_rd(7'h30, d); chk("R1 slave", d, 32'h0);
        bus_rd(7'h7C, d); chk("R1 buffer", d, 32'h0);
    endtask

    task automatic t_buffer();
        fill(3);
        load_buf();
        chk_buf("R2 readback", 0, 1'b0);
    endtask

    task automatic t_full_duplex();
        logic [31:0] d;
        fill(11);
        setup(40, 1'b1, 1'b0, 1);
        bus_wr(7'h00, 32'h0004_0000);
        repeat (3) @(negedge clk);
        bus_rd(7'h00, d); chk("R3 busy readback", d, 32'h0004_0000);
        wait_done("R7 done after full duplex");
        chk("R4 edge count", 32'(rise_cnt - rise_base), 32'd40);
        chk_mosi("R4 mosi order", 40);
        chk_buf("R6 capture replaces", 40, 1'b1);
        chk("R8 released", {31'b0, spi_cs_n}, 32'd1);
        chk("R5 cs during sclk", 32'(cs_viol), 32'd0);
    endtask

    task automatic t_partial();
        fill(29);
        setup(12, 1'b0, 1'b0, 0);
        bus_wr(7'h00, 32'h0004_0000);
        wait_done("R7 done partial");
        chk("R4 12-bit edges", 32'(rise_cnt - rise_base), 32'd12);
        chk_mosi("R4 12-bit mosi", 12);
        chk_buf("R6 no capture", 12, 1'b0);
    endtask

    task automatic t_timing();
        fill(5);
        setup(8, 1'b1, 1'b0, 3);
        bus_wr(7'h00, 32'h0004_0000);
        wait_done("R7 done timing");
        chk("R5 lead time", 32'(t_first - t_csf), 32'd80);
        chk("R5 high time", 32'(t_fall - t_rise), 32'd80);
        chk("R8 tail time", 32'(t_csr - t_fall), 32'd80);
        chk_mosi("R5 mode0 mosi", 8);
        chk_buf("R5 mode0 sample", 8, 1'b1);
    endtask

    task automatic t_done_clear();
        logic [31:0] d;
        bus_wr(7'h30, 32'h10);
        bus_rd(7'h30, d); chk("R7 write1 keeps", d, 32'h10);
        bus_wr(7'h30, 32'h0);
        bus_rd(7'h30, d); chk("R7 write0 clears", d, 32'h0);
    endtask

    task automatic t_hold();
        int r0;
        fill(17);
        setup(16, 1'b1, 1'b1, 1);
        r0 = cs_rise_cnt;
        bus_wr(7'h00, 32'h0004_0000);
        wait_done("R7 done hold");
        repeat (10) @(negedge clk);
        chk("R8 held low", {31'b0, spi_cs_n}, 32'd0);
        chk("R8 no rise", 32'(cs_rise_cnt - r0), 32'd0);
        fill(23);
        setup(16, 1'b1, 1'b0, 1);
        bus_wr(7'h00, 32'h0004_0000);
        wait_done("R7 done after hold");
        chk("R8 released after", {31'b0, spi_cs_n}, 32'd1);
        chk("R8 single rise", 32'(cs_rise_cnt - r0), 32'd1);
        chk_mosi("R8 second data", 16);
    endtask

    task automatic t_busy();
        logic [31:0] d;
        fill(41);
        setup(32, 1'b1, 1'b0, 1);
        bus_wr(7'h00, 32'h0004_0000);
        repeat (10) @(negedge clk);
        bus_wr(7'h00, 32'h0004_0000);
        bus_wr(7'h40, 32'hDEAD_BEEF);
        bus_wr(7'h20, 32'(7) << 17);
        wait_done("R9 done");
        chk("R9 edges unchanged", 32'(rise_cnt - rise_base), 32'd32);
        bus_rd(7'h20, d); chk("R12 user1 kept", d, 32'(31) << 17);
        chk_buf("R12 buffer write ignored", 32, 1'b1);
    endtask

    task automatic t_blocked();
        logic [31:0] d;
        bus_wr(7'h30, 32'h0);
        bus_wr(7'h08, 32'h0002_0000);
        bus_wr(7'h20, 32'(7) << 17);
        arm();
        bus_wr(7'h00, 32'h0004_0000);
        repeat (20) @(negedge clk);
        chk("R10 map no edges", 32'(rise_cnt - rise_base), 32'd0);
        chk("R10 map cs high", {31'b0, spi_cs_n}, 32'd1);
        bus_rd(7'h00, d); chk("R10 map idle", d, 32'h0);
        bus_wr(7'h08, 32'h0);
        bus_wr(7'h30, 32'h4000_0000);
        bus_rd(7'h30, d); chk("R10 mode readback", d, 32'h4000_0000);
        bus_wr(7'h00, 32'h0004_0000);
        repeat (20) @(negedge clk);
        chk("R10 slave no edges", 32'(rise_cnt - rise_base), 32'd0);
        chk("R10 slave cs high", {31'b0, spi_cs_n}, 32'd1);
        bus_wr(7'h30, 32'h0);
    endtask

    task automatic t_soft_reset();
        logic [31:0] d;
        int r1;
        fill(53);
        setup(512, 1'b1, 1'b1, 0);
        bus_wr(7'h00, 32'h0004_0000);
        repeat (30) @(negedge clk);
        bus_wr(7'h30, 32'h8000_0000);
        chk("R11 cs released", {31'b0, spi_cs_n}, 32'd1);
        chk("R11 sclk low", {31'b0, spi_sclk}, 32'd0);
        bus_rd(7'h00, d); chk("R11 not busy", d, 32'h0);
        bus_rd(7'h30, d); chk("R11 slave reads", d, 32'h0);
        r1 = rise_cnt;
        repeat (20) @(negedge clk);
        chk("R11 sclk stopped", 32'(rise_cnt - r1), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_buffer();
        t_full_duplex();
        t_partial();
        t_timing();
        t_done_clear();
        t_hold();
        t_busy();
        t_blocked();
        t_soft_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule